// File: doc/BRIEF.md
# ATA PIO Cycle Timing Generator

This block paces programmed-I/O cycles on a parallel ATA channel that carries two drives. Software loads a small bank of timing fields: one address-setup count for the whole channel, one active/recovery pair for command-block accesses, and one active/recovery pair for data-port accesses on each drive. The counts sit in narrow fields, and a field value of zero stands for the longest count the field can express.

A request names the drive, the direction and the kind of access. The block then chooses the matching timing and holds it for the whole cycle. It runs an address-setup phase, then a phase with the read or write strobe asserted, then a recovery phase. Each phase is measured in clock periods. When recovery ends the block reports completion and accepts the next request.

Top module: `ata_pio_timer`

## Requirements
- R1: The setup field is `cfg_wdata[2:0]` written at `cfg_addr` 0. A value of 1 to 7 gives that many setup clocks (ready low, no strobe) after acceptance, and 0 gives 8.
- R2: In a timing byte the active count lives in bits 6:4. A value of 1 to 7 keeps the strobe high for that many clocks, and 0 gives 8.
- R3: In a timing byte the recovery count lives in bits 3:0. A value of 1 to 15 gives that many recovery clocks after the strobe drops and before done, and 0 gives 16.
- R4: The command timing byte is at `cfg_addr` 1 and serves accesses with `req_data`=0. The data timing bytes are at `cfg_addr` 2 for drive 0 and `cfg_addr` 3 for drive 1, and they serve accesses with `req_data`=1, chosen by `req_drive`. Writing one drive's byte leaves the other drive's timing unchanged.
- R5: The single setup count applies to both drives and to both access kinds.
- R6: Each cycle runs setup, then active, then recovery. `strb_wr` is the strobe when `req_write`=1 and `strb_rd` when it is 0. The two strobes are never high together.
- R7: `done` is high for exactly one clock, right after the last recovery clock. `req_ready` is high in that same clock.
- R8: `req_ready` stays low from acceptance until done. A request held on `req_valid` during that time is not started until `req_ready` returns high.
- R9: A configuration write made during a cycle leaves that cycle's timing unchanged and takes effect from the next accepted request.
- R10: After reset `req_ready` is 1, the strobes and `done` are 0, and every field is 0, giving 8 setup, 8 active and 16 recovery clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Field select: 0 setup, 1 command byte, 2 drive 0 data byte, 3 drive 1 data byte |
| cfg_wdata | input | 8 | Configuration write data |
| req_valid | input | 1 | Cycle request |
| req_ready | output | 1 | High when a request can be accepted |
| req_drive | input | 1 | Drive select (0 or 1) |
| req_write | input | 1 | 1 for a write strobe, 0 for a read strobe |
| req_data | input | 1 | 1 for a data-port access, 0 for a command-block access |
| strb_rd | output | 1 | Read strobe, high while asserted |
| strb_wr | output | 1 | Write strobe, high while asserted |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench builds the block with its default field widths: 3 bits for setup, 3 bits for active and 4 bits for recovery. At these widths every field extreme takes only tens of clocks. This makes it cheap to run both the zero-means-maximum encodings (8, 8, 16) and the one-clock minimums on every path. The scoreboard measures setup, active and recovery lengths at the ports, so wrong field positions, a wrong drive or byte choice, and timing that changes in the middle of a cycle all show up as length mismatches.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACTIVE = 2'd2,
      PH_RECOV  = 2'd3
   } pio_phase_e;

   localparam int CFG_ADDR_W     = 2;
   localparam int CFG_ADDR_SETUP = 0;
   localparam int CFG_ADDR_CMD   = 1;
   localparam int CFG_ADDR_DAT0  = 2;
   localparam int NUM_DRV        = 2;
endpackage

// File: rtl/pio_cnt_decode.sv
module pio_cnt_decode #(
   parameter int IN_W  = 3,
   parameter int OUT_W = 5
) (
   input  logic [IN_W-1:0]  field,
   output logic [OUT_W-1:0] count
);
   generate
      if (OUT_W <= IN_W) begin : g_bad
         $error("pio_cnt_decode: OUT_W must exceed IN_W");
      end
   endgenerate

   // zero encodes the largest count, 2**IN_W
   always_comb begin
      if (field == '0) count = OUT_W'(1) << IN_W;
      else             count = {{(OUT_W-IN_W){1'b0}}, field};
   end
endmodule

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
   import ata_pio_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int SETUP_W = 3,
   parameter int TIM_W   = 7
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [CFG_ADDR_W-1:0]   cfg_addr,
   input  logic [DATA_W-1:0]       cfg_wdata,
   output logic [SETUP_W-1:0]      setup_q,
   output logic [TIM_W-1:0]        cmd_q,
   output logic [NUM_DRV*TIM_W-1:0] dat_q
);
   generate
      if (TIM_W >= DATA_W || SETUP_W > DATA_W) begin : g_bad
         $error("pio_timing_regs: fields do not fit the write data");
      end
   endgenerate

   logic unused_hi;
   assign unused_hi = ^cfg_wdata[DATA_W-1:TIM_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         setup_q <= '0;
         cmd_q   <= '0;
      end else if (cfg_we) begin
         if (cfg_addr == CFG_ADDR_W'(CFG_ADDR_SETUP)) setup_q <= cfg_wdata[SETUP_W-1:0];
         if (cfg_addr == CFG_ADDR_W'(CFG_ADDR_CMD))   cmd_q   <= cfg_wdata[TIM_W-1:0];
      end
   end

   for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            dat_q[d*TIM_W +: TIM_W] <= '0;
         else if (cfg_we && cfg_addr == CFG_ADDR_W'(CFG_ADDR_DAT0 + d))
            dat_q[d*TIM_W +: TIM_W] <= cfg_wdata[TIM_W-1:0];
      end
   end
endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
   import ata_pio_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [CNT_W-1:0] ld_setup,
   input  logic [CNT_W-1:0] ld_act,
   input  logic [CNT_W-1:0] ld_rec,
   output logic             req_ready,
   output logic             strb_rd,
   output logic             strb_wr,
   output logic             done
);
   pio_phase_e       state;
   logic [CNT_W-1:0] cnt, act_q, rec_q;
   logic             wr_q;
   logic             last;

   assign last      = (cnt == CNT_W'(1));
   assign req_ready = (state == PH_IDLE);
   assign strb_rd   = (state == PH_ACTIVE) && !wr_q;
   assign strb_wr   = (state == PH_ACTIVE) &&  wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PH_IDLE;
         cnt   <= '0;
         act_q <= '0;
         rec_q <= '0;
         wr_q  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= (state == PH_RECOV) && last;
         case (state)
            PH_IDLE: if (req_valid) begin
               state <= PH_SETUP;
               cnt   <= ld_setup;
               act_q <= ld_act;
               rec_q <= ld_rec;
               wr_q  <= req_write;
            end
            PH_SETUP: if (last) begin
               state <= PH_ACTIVE;
               cnt   <= act_q;
            end else cnt <= cnt - 1'b1;
            PH_ACTIVE: if (last) begin
               state <= PH_RECOV;
               cnt   <= rec_q;
            end else cnt <= cnt - 1'b1;
            default: if (last) state <= PH_IDLE;
                     else      cnt   <= cnt - 1'b1;
         endcase
      end
   end

   p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(strb_rd && strb_wr));
   p_strobe_after_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strb_rd || strb_wr) |-> $past(state) == PH_SETUP);
   p_strobe_into_recov_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strb_rd || strb_wr) |-> state == PH_RECOV);
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);
   p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !(state == PH_RECOV && last)) |=> !req_ready);
   p_accept_only_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_ready) |-> $past(req_valid));
   p_cnt_live: assert property (@(posedge clk) disable iff (!rst_n)
      (state != PH_IDLE) |-> cnt != '0);
endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer
   import ata_pio_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int SETUP_W = 3,
   parameter int ACT_W   = 3,
   parameter int REC_W   = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [CFG_ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0]     cfg_wdata,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_drive,
   input  logic                  req_write,
   input  logic                  req_data,
   output logic                  strb_rd,
   output logic                  strb_wr,
   output logic                  done
);
   localparam int TIM_W = ACT_W + REC_W;
   localparam int MAX_W = (SETUP_W > ACT_W) ? ((SETUP_W > REC_W) ? SETUP_W : REC_W)
                                            : ((ACT_W > REC_W) ? ACT_W : REC_W);
   localparam int CNT_W = MAX_W + 1;

   generate
      if (SETUP_W < 1 || ACT_W < 1 || REC_W < 1) begin : g_bad
         $error("ata_pio_timer: field widths must be positive");
      end
   endgenerate

   logic [SETUP_W-1:0]       setup_q;
   logic [TIM_W-1:0]         cmd_q, sel_byte;
   logic [NUM_DRV*TIM_W-1:0] dat_q;
   logic [CNT_W-1:0]         n_setup, n_act, n_rec;

   pio_timing_regs #(.DATA_W(DATA_W), .SETUP_W(SETUP_W), .TIM_W(TIM_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .setup_q(setup_q), .cmd_q(cmd_q), .dat_q(dat_q));

   // command-block accesses share one byte; data-port accesses use the drive's byte
   always_comb begin
      if (req_data) sel_byte = dat_q[req_drive*TIM_W +: TIM_W];
      else          sel_byte = cmd_q;
   end

   pio_cnt_decode #(.IN_W(SETUP_W), .OUT_W(CNT_W)) u_dec_setup (
      .field(setup_q), .count(n_setup));
   pio_cnt_decode #(.IN_W(ACT_W), .OUT_W(CNT_W)) u_dec_act (
      .field(sel_byte[REC_W +: ACT_W]), .count(n_act));
   pio_cnt_decode #(.IN_W(REC_W), .OUT_W(CNT_W)) u_dec_rec (
      .field(sel_byte[REC_W-1:0]), .count(n_rec));

   pio_cycle_seq #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .ld_setup(n_setup), .ld_act(n_act), .ld_rec(n_rec),
      .req_ready(req_ready), .strb_rd(strb_rd), .strb_wr(strb_wr), .done(done));

   p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (req_ready && !done));
endmodule

// File: tb/tb_ata_pio_timer.sv
module tb_ata_pio_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic       req_valid = 1'b0, req_drive = 1'b0, req_write = 1'b0, req_data = 1'b0;
   logic       req_ready, strb_rd, strb_wr, done;

   always #4 clk = ~clk;

   ata_pio_timer dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
      .req_drive(req_drive), .req_write(req_write), .req_data(req_data),
      .strb_rd(strb_rd), .strb_wr(strb_wr), .done(done));

   typedef struct {
      int    s, a, r;
      bit    wr;
      string tag;
   } exp_t;
   exp_t exp_q[$];

   int checks = 0, errors = 0;
   logic [2:0] m_setup = '0;
   logic [7:0] m_cmd = '0;
   logic [7:0] m_dat[2] = '{8'h00, 8'h00};

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int dec(int v, int w);
      return (v == 0) ? (1 << w) : v;
   endfunction

   task automatic cfg_write(int addr, int val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 2'(addr); cfg_wdata = 8'(val);
      @(negedge clk);
      cfg_we = 1'b0;
      case (addr)
         0: m_setup = 3'(val);
         1: m_cmd = 8'(val);
         2: m_dat[0] = 8'(val);
         default: m_dat[1] = 8'(val);
      endcase
   endtask

   // drive a request; returns the number of clocks it was held off
   task automatic issue(bit drv, bit wr, bit dat, string tag, output int held);
      exp_t e;
      logic [7:0] b;
      held = 0;
      @(negedge clk);
      req_valid = 1'b1; req_drive = drv; req_write = wr; req_data = dat;
      while (!req_ready) begin
         held++;
         @(negedge clk);
      end
      b = dat ? m_dat[drv] : m_cmd;
      e.s = dec(int'(m_setup), 3);
      e.a = dec(int'(b[6:4]), 3);
      e.r = dec(int'(b[3:0]), 4);
      e.wr = wr; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " R8 ready low after acceptance"}, int'(req_ready), 0);
   endtask

   // monitor: measures phase lengths at the ports and scores them
   int  ms = 0, ma = 0, mr = 0;
   bit  seen_rd = 0, seen_wr = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            exp_t e;
            chk("R7 ready with done", int'(req_ready), 1);
            if (exp_q.size() == 0) begin
               chk("R7 unexpected done", 1, 0);
            end else begin
               e = exp_q.pop_front();
               chk({e.tag, " R1 setup clocks"}, ms, e.s);
               chk({e.tag, " R2 active clocks"}, ma, e.a);
               chk({e.tag, " R3 recovery clocks"}, mr, e.r);
               chk({e.tag, " R6 write strobe used"}, int'(seen_wr), int'(e.wr));
               chk({e.tag, " R6 read strobe used"}, int'(seen_rd), int'(!e.wr));
            end
            ms = 0; ma = 0; mr = 0; seen_rd = 0; seen_wr = 0;
         end else if (!req_ready) begin
            if (strb_rd && strb_wr) chk("R6 both strobes", 1, 0);
            if (strb_rd || strb_wr) begin
               if (mr != 0) chk("R6 strobe during recovery", mr, 0);
               ma++;
               seen_rd |= strb_rd; seen_wr |= strb_wr;
            end else if (ma == 0) ms++;
            else mr++;
         end else if (strb_rd || strb_wr) begin
            chk("R6 strobe while idle", 1, 0);
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL R7 watchdog: actual 0 expected 1 completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      int held;
      repeat (3) @(negedge clk);
      chk("R10 reset ready", int'(req_ready), 1);
      chk("R10 reset strobes", int'(strb_rd | strb_wr), 0);
      chk("R10 reset done", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset fields give 8/8/16
      issue(0, 0, 0, "R10 defaults", held);
      issue(1, 1, 1, "R10 defaults data", held);

      // R1, R2, R3, R4: command byte
      cfg_write(0, 3);
      cfg_write(1, 8'h25);
      issue(0, 0, 0, "R4 cmd read", held);
      issue(1, 1, 0, "R4 cmd write drv1", held);

      // R4, R5: per-drive data bytes, shared setup
      cfg_write(2, 8'h71);
      cfg_write(3, 8'h13);
      issue(0, 1, 1, "R4 data drv0", held);
      issue(1, 0, 1, "R5 data drv1", held);
      cfg_write(3, 8'h4A);
      issue(0, 0, 1, "R4 drv0 unchanged", held);

      // R1, R2, R3 minimum and maximum nonzero fields
      cfg_write(0, 1);
      cfg_write(1, 8'h11);
      issue(0, 1, 0, "R1 minimum", held);
      cfg_write(0, 7);
      cfg_write(1, 8'h7F);
      issue(0, 0, 0, "R3 maximum nonzero", held);
      cfg_write(1, 8'h80);
      issue(0, 0, 0, "R2 bit7 ignored", held);

      // R8: back-to-back with valid held while busy
      cfg_write(0, 2);
      cfg_write(1, 8'h23);
      issue(0, 1, 0, "R8 first", held);
      issue(0, 0, 0, "R8 second", held);
      chk("R8 held-off clocks", int'(held > 0), 1);

      // R9: write during a cycle
      cfg_write(3, 8'h32);
      issue(1, 1, 1, "R9 old timing", held);
      cfg_write(3, 8'h54);
      cfg_write(0, 4);
      issue(1, 1, 1, "R9 new timing", held);

      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
      chk("R7 done single clock", int'(done), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule